// File: doc/BRIEF.md
# Comparator Change Interrupt Generator

This block samples three asynchronous comparator outputs, brings them into the clock domain, and presents their settled levels as a three-bit read-only status word. It also watches for level changes on a software-selected source and raises a sticky interrupt request toward a microcontroller, which acknowledges it with a one-cycle clear pulse.

The source is picked by a two-bit enable field written through a simple write strobe. Either of the two upper comparators can be watched alone. With both enable bits set, they are merged by exclusive-OR into a single source, so that one interrupt reports a change of their parity rather than two separate events. The first comparator only appears in the status word and never raises an interrupt. A change is any transition, rising or falling. Rewriting the enable field never produces an interrupt by itself, because the previous levels of every comparator are tracked all the time, whichever source is selected.

Top module: `cmpirq_top`

## Requirements
- R1: After reset, `irq_o` is 0, `status_o` is 000, and the enable field is 00, so a comparator change raises no interrupt until the field is written.
- R2: `status_o` bit 0 shows comparator 1, bit 1 comparator 2 and bit 2 comparator 3. Each bit follows its input with a lag of two rising clock edges.
- R3: With enable field 00, no change on any comparator sets `irq_o`.
- R4: With enable field 01, a rising or falling change of comparator 2 (`cmp_raw_i[1]`) sets `irq_o`. Changes of comparators 1 and 3 do not.
- R5: With enable field 10, a rising or falling change of comparator 3 (`cmp_raw_i[2]`) sets `irq_o`. Changes of comparators 1 and 2 do not.
- R6: With enable field 11, `irq_o` is set when the XOR of comparators 2 and 3 changes. A single toggle of either one sets it. Both toggling in the same cycle does not.
- R7: Once set, `irq_o` stays 1 until a cycle with `irq_clr_i` = 1 and no new change. It is 0 after that edge.
- R8: When a new change and `irq_clr_i` fall in the same cycle, `irq_o` stays 1.
- R9: Writing a new value to the enable field while the comparator inputs are steady does not set `irq_o`.
- R10: An input change applied between two clock edges makes `irq_o` rise at the third rising edge after it, and not before.
- R11: Comparator 1 (`cmp_raw_i[0]`) never sets `irq_o`, under any enable value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_raw_i | input | 3 | Raw comparator outputs, asynchronous to `clk` |
| cfg_we_i | input | 1 | Write strobe for the enable field |
| cfg_wdata_i | input | 2 | New enable value: bit 0 selects comparator 2, bit 1 comparator 3, both selects their XOR |
| status_o | output | 3 | Synchronized comparator levels |
| irq_o | output | 1 | Sticky interrupt request |
| irq_clr_i | input | 1 | One-cycle acknowledge that clears `irq_o` |

## Verification
Two functions can land on the same edge: the acknowledge that clears the pending request and the detection of a fresh change that sets it. The bench leaves a request pending, then toggles comparator 2. It counts two edges, so the change is visible to the detector, and raises the clear for exactly the following edge. The request must still read 1 after that edge. A plain clear one cycle later must then drop it, which shows that the clear path was live and that the set path won the conflict.

// File: rtl/cmpirq_pkg.sv
package cmpirq_pkg;

    // Source selection carried by the two-bit enable field.
    typedef enum logic [1:0] {
        SRC_OFF = 2'b00,
        SRC_B   = 2'b01,
        SRC_C   = 2'b10,
        SRC_XOR = 2'b11
    } src_sel_e;

    // Detector state: active selection plus last-seen levels of both watched comparators.
    typedef struct packed {
        src_sel_e sel;
        logic     prev_b;
        logic     prev_c;
    } det_state_t;

    // Request flag state.
    typedef struct packed {
        logic pend;
    } flag_state_t;

endpackage

// File: rtl/cmpirq_sync.sv
module cmpirq_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_d;
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[g] <= '0;
                end else begin
                    chain_q[g] <= chain_d[g];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[LAST];

endmodule

// File: rtl/cmpirq_detect.sv
module cmpirq_detect
    import cmpirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we_i,
    input  logic [1:0] cfg_wdata_i,
    input  logic       lvl_b_i,
    input  logic       lvl_c_i,
    output logic       chg_o,
    output src_sel_e   sel_o
);

    det_state_t st_d;
    det_state_t st_q;
    logic       flip_b;
    logic       flip_c;
    logic       chg;

    always_comb begin
        flip_b = lvl_b_i ^ st_q.prev_b;
        flip_c = lvl_c_i ^ st_q.prev_c;

        unique case (st_q.sel)
            SRC_B:   chg = flip_b;
            SRC_C:   chg = flip_c;
            SRC_XOR: chg = flip_b ^ flip_c;
            default: chg = 1'b0;
        endcase

        st_d        = st_q;
        st_d.prev_b = lvl_b_i;
        st_d.prev_c = lvl_c_i;
        if (cfg_we_i) begin
            st_d.sel = src_sel_e'(cfg_wdata_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sel: SRC_OFF, prev_b: 1'b0, prev_c: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign chg_o = chg;
    assign sel_o = st_q.sel;

endmodule

// File: rtl/cmpirq_flag.sv
module cmpirq_flag
    import cmpirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    flag_state_t fl_d;
    flag_state_t fl_q;

    always_comb begin
        fl_d = fl_q;
        if (set_i) begin
            fl_d.pend = 1'b1;
        end else if (clr_i) begin
            fl_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '{pend: 1'b0};
        end else begin
            fl_q <= fl_d;
        end
    end

    assign pend_o = fl_q.pend;

endmodule

// File: rtl/cmpirq_top.sv
module cmpirq_top
    import cmpirq_pkg::*;
#(
    parameter int N_CMP       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CMP-1:0] cmp_raw_i,
    input  logic             cfg_we_i,
    input  logic [1:0]       cfg_wdata_i,
    output logic [N_CMP-1:0] status_o,
    output logic             irq_o,
    input  logic             irq_clr_i
);

    localparam int IDX_B = 1;
    localparam int IDX_C = 2;

    logic [N_CMP-1:0] lvl;
    logic             chg_w;
    src_sel_e         sel_w;

    cmpirq_sync #(
        .WIDTH  (N_CMP),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cmp_raw_i),
        .sync_o  (lvl)
    );

    cmpirq_detect u_det (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we_i    (cfg_we_i),
        .cfg_wdata_i (cfg_wdata_i),
        .lvl_b_i     (lvl[IDX_B]),
        .lvl_c_i     (lvl[IDX_C]),
        .chg_o       (chg_w),
        .sel_o       (sel_w)
    );

    cmpirq_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (chg_w),
        .clr_i  (irq_clr_i),
        .pend_o (irq_o)
    );

    assign status_o = lvl;

endmodule

// File: rtl/cmpirq_chk.sv
module cmpirq_chk #(
    parameter int N_CMP       = 3,
    parameter int SYNC_STAGES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_CMP-1:0] cmp_raw,
    input logic [N_CMP-1:0] status,
    input logic             irq,
    input logic             irq_clr,
    input logic             chg,
    input logic [1:0]       sel
);

    logic [1:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (cyc_q != 2'd3) begin
            cyc_q <= cyc_q + 2'd1;
        end
    end

    generate
        if (SYNC_STAGES == 2) begin : g_lag
            p_status_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (cyc_q >= 2'd2) |-> (status == $past(cmp_raw, 2)));
        end
    endgenerate

    p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00) |-> !chg);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !chg) |=> !irq);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> irq);

    p_rise_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(chg));

endmodule

bind cmpirq_top cmpirq_chk #(
    .N_CMP       (N_CMP),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmp_raw (cmp_raw_i),
    .status  (status_o),
    .irq     (irq_o),
    .irq_clr (irq_clr_i),
    .chg     (chg_w),
    .sel     (sel_w)
);

// File: tb/sim_cmpirq_top.sv
`timescale 1ns/1ps
module sim_cmpirq_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmp_raw = 3'b000;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_wdata = 2'b00;
    logic [2:0] status;
    logic       irq;
    logic       irq_clr = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cmpirq_top u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_raw_i   (cmp_raw),
        .cfg_we_i    (cfg_we),
        .cfg_wdata_i (cfg_wdata),
        .status_o    (status),
        .irq_o       (irq),
        .irq_clr_i   (irq_clr)
    );

    // Vector: [5:4] enable field, [3:1] comparator levels, [0] expected request.
    localparam int NV = 14;
    localparam logic [5:0] VEC [NV] = '{
        {2'b00, 3'b111, 1'b0},
        {2'b00, 3'b000, 1'b0},
        {2'b01, 3'b010, 1'b1},
        {2'b01, 3'b000, 1'b1},
        {2'b01, 3'b101, 1'b0},
        {2'b10, 3'b101, 1'b0},
        {2'b10, 3'b001, 1'b1},
        {2'b10, 3'b011, 1'b0},
        {2'b11, 3'b011, 1'b0},
        {2'b11, 3'b001, 1'b1},
        {2'b11, 3'b110, 1'b0},
        {2'b11, 3'b100, 1'b1},
        {2'b01, 3'b100, 1'b0},
        {2'b00, 3'b010, 1'b0}
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 1:    return "R3";
            2, 3:    return "R4";
            4:       return "R11";
            5, 8:    return "R9";
            6, 7:    return "R5";
            9, 10, 11: return "R6";
            12:      return "R9";
            default: return "R3";
        endcase
    endfunction

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    task automatic wr_en(logic [1:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset irq", irq, 0);
        chk("R1 reset status", status, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Untouched enable field after reset: change of comparator 2 ignored.
        cmp_raw = 3'b010;
        repeat (4) @(negedge clk);
        chk("R1 default enable off", irq, 0);
        cmp_raw = 3'b000;
        repeat (4) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            wr_en(VEC[i][5:4]);
            cmp_raw = VEC[i][3:1];
            repeat (4) @(negedge clk);
            chk($sformatf("%s vec%0d irq", vec_tag(i), i), irq, VEC[i][0]);
            chk($sformatf("R2 vec%0d status", i), status, VEC[i][3:1]);
            pulse_clr();
            chk($sformatf("R7 vec%0d cleared", i), irq, 0);
        end

        // Latency: state is en 00, levels 010.
        wr_en(2'b01);
        cmp_raw = 3'b000;
        @(negedge clk);
        chk("R10 after edge1", irq, 0);
        chk("R2 status after edge1", status, 3'b010);
        @(negedge clk);
        chk("R10 after edge2", irq, 0);
        chk("R2 status after edge2", status, 3'b000);
        @(negedge clk);
        chk("R10 after edge3", irq, 1);

        // Sticky.
        repeat (10) @(negedge clk);
        chk("R7 sticky", irq, 1);

        // Clear coinciding with a new change.
        cmp_raw = 3'b010;
        repeat (2) @(negedge clk);
        pulse_clr();
        chk("R8 set beats clear", irq, 1);
        pulse_clr();
        chk("R7 plain clear", irq, 0);

        // Comparator 1 under XOR selection.
        wr_en(2'b11);
        cmp_raw = 3'b011;
        repeat (4) @(negedge clk);
        chk("R11 cmp1 under xor", irq, 0);

        // Reset with a pending request.
        cmp_raw = 3'b001;
        repeat (4) @(negedge clk);
        chk("R6 xor single toggle", irq, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset irq", irq, 0);
        chk("R1 mid reset status", status, 0);
        rst_n = 1'b1;
        cmp_raw = 3'b110;
        repeat (4) @(negedge clk);
        chk("R1 enable cleared by reset", irq, 0);

        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog got=timeout expected=finish");
            summary();
        end
    end

endmodule